// File: doc/BRIEF.md
# Dual-Path Register Load Controller

This block is the host-facing register loader of a direct digital synthesizer. A host reaches it through two independent staging registers. The first is a 32-bit parallel assembly register, filled through a 16-bit data bus under an active-low write strobe and an active-low chip select. Each write shifts the register left by one byte or by one half-word and places the new bus data in the low bits. The second is a 32-bit serial assembly register, filled one bit per rising edge of a serial clock, most significant bit first.

A 4-bit transfer code and a LOAD strobe copy one staging register into one destination register. The destinations are two frequency words, a phase word, an IQ modulation word and an 8-bit command register. Bit 0 of the command register selects the parallel write width. Bit 1 of the command register is brought out as the IQ bypass flag. The host may run asynchronously to the system clock. For that reason the write activity, the serial clock, the serial data and LOAD each pass through a two-flop synchronizer, and each acts once per rising transition.

Top module: `dual_path_loader`

## Requirements
- R1: A synchronous active-high reset clears both staging registers, all four 32-bit destinations and the command register. After reset the parallel path is in byte mode and `iqBypass` is 0.
- R2: In byte mode (command bit 0 = 0), each completed parallel write shifts the parallel staging register left by 8 bits and loads `busData[7:0]` into bits 7..0.
- R3: In half-word mode (command bit 0 = 1), each completed parallel write shifts the parallel staging register left by 16 bits and loads `busData[15:0]` into bits 15..0.
- R4: A parallel write takes place only while `wrN` and `csN` are both low. A `wrN` pulse while `csN` is high leaves the parallel staging register unchanged.
- R5: Each rising edge of `sclk` shifts the serial staging register left by one bit and loads `sdata` into bit 0, so the first bit sent ends up as the most significant bit.
- R6: A transfer from the parallel register uses codes 0000, 0001, 0010 and 0011, which load `freq0`, `freq1`, `phase` and `iqMod` in that order. A transfer from the serial register uses codes 1100, 1101, 1110 and 1111, which load the same four destinations in the same order.
- R7: Code 1000 loads bits 7..0 of the parallel staging register into `cmdReg`. The output `iqBypass` equals `cmdReg` bit 1, so a command value of 2 sets it.
- R8: Every other code makes no transfer. No code loads `cmdReg` from the serial staging register.
- R9: Each rising transition of `load` makes exactly one transfer, however many system clock cycles `load` stays high.
- R10: When a transfer and a write to its source staging register are detected in the same cycle, the destination receives the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busData | input | 16 | Parallel write data |
| wrN | input | 1 | Write strobe, active low |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| load | input | 1 | Transfer strobe; acts on its rising transition |
| tcode | input | 4 | Transfer code selecting source and destination |
| freq0 | output | 32 | Frequency word 0 |
| freq1 | output | 32 | Frequency word 1 |
| phase | output | 32 | Phase word |
| iqMod | output | 32 | IQ modulation word |
| cmdReg | output | 8 | Command register |
| iqBypass | output | 1 | IQ bypass flag, equal to command bit 1 |

## Verification
A parallel write and a LOAD transfer can be detected in the same system clock cycle. A transfer that reads the parallel staging register then competes with the shift that rewrites it. The bench provokes this by lowering `wrN` and `csN` and raising `load` at the same instant, so that both pass through synchronizers of equal depth and emerge together. It then judges the outcome twice. The destination must hold the value from before the write, and a later transfer must show the shifted value.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef struct packed {
    logic       parWrite;
    logic       serShift;
    logic       serBit;
    logic       xferEn;
    logic [3:0] xferCode;
  } loadStrobe_t;

  localparam logic [3:0] CODE_CMD = 4'b1000;
  localparam logic [1:0] SRC_PAR  = 2'b00;
  localparam logic [1:0] SRC_SER  = 2'b11;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
      last <= 1'b0;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      last <= pipe[STAGES-1];
    end
  end

  assign rise = pipe[STAGES-1] & ~last;
endmodule

// File: rtl/load_ctrl.sv
module load_ctrl
  import loader_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdata,
  input  logic        load,
  input  logic [3:0]  tcode,
  output loadStrobe_t strb
);
  logic              wrActive;
  logic              wrRise;
  logic              sclkRise;
  logic              loadRise;
  logic [STAGES-1:0] sdPipe;

  assign wrActive = ~wrN & ~csN;

  edge_sync #(.STAGES(STAGES)) u_wrSync   (.clk(clk), .rst(rst), .din(wrActive), .rise(wrRise));
  edge_sync #(.STAGES(STAGES)) u_sclkSync (.clk(clk), .rst(rst), .din(sclk),     .rise(sclkRise));
  edge_sync #(.STAGES(STAGES)) u_loadSync (.clk(clk), .rst(rst), .din(load),     .rise(loadRise));

  // serial data delayed by the same depth as the serial clock
  always_ff @(posedge clk) begin
    if (rst) sdPipe <= '0;
    else     sdPipe <= {sdPipe[STAGES-2:0], sdata};
  end

  always_comb begin
    strb.parWrite = wrRise;
    strb.serShift = sclkRise;
    strb.serBit   = sdPipe[STAGES-1];
    strb.xferEn   = loadRise;
    strb.xferCode = tcode;
  end
endmodule

// File: rtl/load_datapath.sv
module load_datapath
  import loader_pkg::*;
#(
  parameter int ASM_W = 32,
  parameter int BUS_W = 16,
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  loadStrobe_t      strb,
  input  logic [BUS_W-1:0] busData,
  output logic [ASM_W-1:0] parAsm,
  output logic [ASM_W-1:0] serAsm,
  output logic [ASM_W-1:0] freq0,
  output logic [ASM_W-1:0] freq1,
  output logic [ASM_W-1:0] phase,
  output logic [ASM_W-1:0] iqMod,
  output logic [CMD_W-1:0] cmdReg
);
  localparam int NARROW = BUS_W / 2;
  localparam int NDEST  = 4;

  logic             wideMode;
  logic [ASM_W-1:0] dest [NDEST];

  assign wideMode = cmdReg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      parAsm <= '0;
      serAsm <= '0;
    end else begin
      if (strb.parWrite) begin
        if (wideMode) parAsm <= {parAsm[ASM_W-BUS_W-1:0], busData};
        else          parAsm <= {parAsm[ASM_W-NARROW-1:0], busData[NARROW-1:0]};
      end
      if (strb.serShift) serAsm <= {serAsm[ASM_W-2:0], strb.serBit};
    end
  end

  genvar g;
  generate
    for (g = 0; g < NDEST; g++) begin : g_dest
      always_ff @(posedge clk) begin
        if (rst) dest[g] <= '0;
        else if (strb.xferEn && strb.xferCode[1:0] == 2'(g)) begin
          if (strb.xferCode[3:2] == SRC_PAR)      dest[g] <= parAsm;
          else if (strb.xferCode[3:2] == SRC_SER) dest[g] <= serAsm;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cmdReg <= '0;
    else if (strb.xferEn && strb.xferCode == CODE_CMD) cmdReg <= parAsm[CMD_W-1:0];
  end

  assign freq0 = dest[0];
  assign freq1 = dest[1];
  assign phase = dest[2];
  assign iqMod = dest[3];
endmodule

// File: rtl/dual_path_loader.sv
module dual_path_loader
  import loader_pkg::*;
#(
  parameter int ASM_W  = 32,
  parameter int BUS_W  = 16,
  parameter int CMD_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] busData,
  input  logic             wrN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdata,
  input  logic             load,
  input  logic [3:0]       tcode,
  output logic [ASM_W-1:0] freq0,
  output logic [ASM_W-1:0] freq1,
  output logic [ASM_W-1:0] phase,
  output logic [ASM_W-1:0] iqMod,
  output logic [CMD_W-1:0] cmdReg,
  output logic             iqBypass
);
  loadStrobe_t      strb;
  logic [ASM_W-1:0] parAsm;
  logic [ASM_W-1:0] serAsm;

  load_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .wrN(wrN), .csN(csN), .sclk(sclk),
    .sdata(sdata), .load(load), .tcode(tcode), .strb(strb)
  );

  load_datapath #(.ASM_W(ASM_W), .BUS_W(BUS_W), .CMD_W(CMD_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .busData(busData),
    .parAsm(parAsm), .serAsm(serAsm), .freq0(freq0), .freq1(freq1),
    .phase(phase), .iqMod(iqMod), .cmdReg(cmdReg)
  );

  assign iqBypass = cmdReg[1];
endmodule

// File: rtl/loader_checker.sv
module loader_checker
  import loader_pkg::*;
#(
  parameter int ASM_W = 32,
  parameter int BUS_W = 16,
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input loadStrobe_t      strb,
  input logic [BUS_W-1:0] busData,
  input logic [ASM_W-1:0] parAsm,
  input logic [ASM_W-1:0] serAsm,
  input logic [ASM_W-1:0] freq0,
  input logic [ASM_W-1:0] freq1,
  input logic [CMD_W-1:0] cmdReg
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (parAsm == '0 && serAsm == '0 && freq0 == '0 && cmdReg == '0));

  p_byte_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (strb.parWrite && !cmdReg[0]) |=>
      (parAsm == {$past(parAsm[ASM_W-9:0]), $past(busData[7:0])}));

  p_ser_shift_r5: assert property (@(posedge clk) disable iff (rst)
    strb.serShift |=> (serAsm == {$past(serAsm[ASM_W-2:0]), $past(strb.serBit)}));

  p_ser_freq1_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.xferEn && strb.xferCode == 4'b1101) |=> (freq1 == $past(serAsm)));

  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(strb.xferEn && strb.xferCode == CODE_CMD) |=> $stable(cmdReg));

  p_single_xfer_r9: assert property (@(posedge clk) disable iff (rst)
    strb.xferEn |=> !strb.xferEn);
endmodule

bind dual_path_loader loader_checker #(.ASM_W(ASM_W), .BUS_W(BUS_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst(rst), .strb(strb), .busData(busData), .parAsm(parAsm),
  .serAsm(serAsm), .freq0(freq0), .freq1(freq1), .cmdReg(cmdReg)
);

// File: tb/test_dual_path_loader.sv
`timescale 1ns/1ps
module test_dual_path_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] busData = '0;
  logic        wrN = 1'b1, csN = 1'b1, sclk = 1'b0, sdata = 1'b0, load = 1'b0;
  logic [3:0]  tcode = '0;
  logic [31:0] freq0, freq1, phase, iqMod;
  logic [7:0]  cmdReg;
  logic        iqBypass;

  dual_path_loader i_dual_path_loader (
    .clk(clk), .rst(rst), .busData(busData), .wrN(wrN), .csN(csN),
    .sclk(sclk), .sdata(sdata), .load(load), .tcode(tcode),
    .freq0(freq0), .freq1(freq1), .phase(phase), .iqMod(iqMod),
    .cmdReg(cmdReg), .iqBypass(iqBypass)
  );

  always #5 clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] f0, f1, ph, iq;
    logic [7:0]  cmd;
  } expItem_t;

  expItem_t    q[$];
  event        chk;
  int          checks = 0, errors = 0, cycles = 0;
  logic [31:0] mPar = '0, mSer = '0, mF0 = '0, mF1 = '0, mPh = '0, mIq = '0;
  logic [7:0]  mCmd = '0;

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] shiftPar(input logic [31:0] p, input logic [15:0] d);
    return mCmd[0] ? {p[15:0], d} : {p[23:0], d[7:0]};
  endfunction

  task automatic modelXfer(input logic [3:0] c);
    case (c)
      4'b0000: mF0 = mPar;  4'b0001: mF1 = mPar;
      4'b0010: mPh = mPar;  4'b0011: mIq = mPar;
      4'b1000: mCmd = mPar[7:0];
      4'b1100: mF0 = mSer;  4'b1101: mF1 = mSer;
      4'b1110: mPh = mSer;  4'b1111: mIq = mSer;
      default: ;
    endcase
  endtask

  task automatic expect_(input string tag);
    expItem_t e;
    e.tag = tag; e.f0 = mF0; e.f1 = mF1; e.ph = mPh; e.iq = mIq; e.cmd = mCmd;
    q.push_back(e);
    -> chk;
  endtask

  task automatic parWr(input logic [15:0] d, input logic selected);
    busData = d; csN = ~selected; wrN = 1'b0;
    waitN(5);
    wrN = 1'b1; csN = 1'b1;
    waitN(4);
    if (selected) mPar = shiftPar(mPar, d);
  endtask

  task automatic serWord(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) begin
      sdata = v[i]; waitN(1);
      sclk = 1'b1;  waitN(4);
      sclk = 1'b0;  waitN(3);
    end
    mSer = v;
  endtask

  task automatic xfer(input logic [3:0] c, input string tag);
    tcode = c; waitN(1);
    load = 1'b1; waitN(4);
    load = 1'b0; waitN(4);
    modelXfer(c);
    expect_(tag);
  endtask

  // monitor: compares every queued expectation against the outputs
  initial begin
    forever begin
      @(chk);
      #1;
      while (q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        checks++;
        if (freq0 !== e.f0 || freq1 !== e.f1 || phase !== e.ph || iqMod !== e.iq ||
            cmdReg !== e.cmd || iqBypass !== e.cmd[1]) begin
          errors++;
          $display("FAIL %s: got f0=%h f1=%h ph=%h iq=%h cmd=%h byp=%b exp f0=%h f1=%h ph=%h iq=%h cmd=%h byp=%b",
                   e.tag, freq0, freq1, phase, iqMod, cmdReg, iqBypass,
                   e.f0, e.f1, e.ph, e.iq, e.cmd, e.cmd[1]);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles exp completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    waitN(3);
    rst = 1'b0;
    waitN(2);
    expect_("R1 reset state");

    // R2 byte mode: four writes build a full word
    parWr(16'hAA12, 1'b1); parWr(16'hBB34, 1'b1);
    parWr(16'hCC56, 1'b1); parWr(16'hDD78, 1'b1);
    xfer(4'b0000, "R2 byte-mode word to freq0 (R6 code 0000)");

    // R7 command value 3: half-word mode and IQ bypass
    parWr(16'h0003, 1'b1);
    xfer(4'b1000, "R7 command load and bypass flag");

    // R3 half-word mode
    parWr(16'h1357, 1'b1); parWr(16'h9BDF, 1'b1);
    xfer(4'b0010, "R3 half-word word to phase (R6 code 0010)");
    xfer(4'b0001, "R6 parallel to freq1 code 0001");
    xfer(4'b0011, "R6 parallel to iqMod code 0011");

    // R4 write without chip select is ignored
    parWr(16'hFFFF, 1'b0);
    xfer(4'b0000, "R4 write with csN high ignored");

    // R5 serial word, MSB first
    serWord(32'hC0FFEE01);
    xfer(4'b1101, "R5 serial word to freq1 (R6 code 1101)");
    serWord(32'h8000_0003);
    xfer(4'b1111, "R6 serial to iqMod code 1111");
    xfer(4'b1100, "R6 serial to freq0 code 1100");
    xfer(4'b1110, "R6 serial to phase code 1110");

    // R8 undefined codes, including serial-to-command attempts
    xfer(4'b1001, "R8 code 1001 no effect");
    xfer(4'b1011, "R8 code 1011 no effect");
    xfer(4'b0111, "R8 code 0111 no effect");

    // R9 long LOAD pulse with a write during it: only one transfer
    tcode = 4'b0000; waitN(1);
    load = 1'b1; waitN(4);
    modelXfer(4'b0000);
    parWr(16'h4242, 1'b1);
    waitN(6);
    load = 1'b0; waitN(4);
    expect_("R9 single transfer per LOAD pulse");
    xfer(4'b0000, "R9 next pulse transfers new content");

    // R10 write and transfer detected in the same cycle
    tcode = 4'b0010; busData = 16'h5A5A; waitN(1);
    modelXfer(4'b0010);
    csN = 1'b0; wrN = 1'b0; load = 1'b1;
    waitN(5);
    wrN = 1'b1; csN = 1'b1; load = 1'b0;
    waitN(4);
    mPar = shiftPar(mPar, 16'h5A5A);
    expect_("R10 transfer takes pre-write content");
    xfer(4'b0010, "R10 later transfer shows shifted content");

    // back to byte mode, then reset mid-run
    parWr(16'h0000, 1'b1);
    xfer(4'b1000, "R7 command cleared back to byte mode");
    parWr(16'h00EE, 1'b1);
    xfer(4'b0001, "R2 byte shift after mode change");

    rst = 1'b1; waitN(2); rst = 1'b0; waitN(2);
    mPar = '0; mSer = '0; mF0 = '0; mF1 = '0; mPh = '0; mIq = '0; mCmd = '0;
    expect_("R1 reset clears destinations");
    parWr(16'h1234, 1'b1);
    xfer(4'b0000, "R1 byte mode after reset");

    waitN(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule